// File: doc/BRIEF.md
# Unaligned Word Merger

This block is the byte-merging datapath behind the partial-word load and store instructions of a 32-bit core. Such an instruction names a byte address that need not be word aligned. The core fetches the aligned word that contains that byte. A left or right fragment of that word is then merged into the destination register for a load, or a fragment of the register is merged into the word for a store. The block is purely combinational: address arithmetic, memory sequencing and fault handling stay in the surrounding pipeline.

The core supplies the effective byte address, the aligned memory word, the current register value (the destination for loads, the store data for stores) and a two-bit operation code. The block returns the aligned address, the merged register value, the merged memory word and a per-byte write mask. Partial stores never raise an alignment fault. They read the aligned word and modify only the bytes they own. Byte ordering is chosen per instance by a parameter. Each little-endian offset behaves like the big-endian offset reflected about the middle of the word.

Top module: `unaligned_merge`

## Requirements
- R1: `aligned_addr_o` equals `addr_i` with its two low bits forced to zero. The byte offset k used below is `addr_i & 3`.
- R2: Operation code 0 (left load), big-endian, offset k: `reg_o` is the memory word shifted left by 8k bits, with the low 8k bits taken from `reg_i`. At offset 0 the whole word is loaded.
- R3: Operation code 1 (right load), big-endian, offset k: `reg_o` is the memory word shifted right by 8(3-k) bits, with the high 8(3-k) bits taken from `reg_i`. At offset 3 the whole word is loaded.
- R4: With the little-endian parameter, every operation at offset k behaves as the big-endian operation at offset 3-k. The left load therefore transfers the whole word at offset 3, and the right load transfers it at offset 0.
- R5: Operation code 2 (left store), big-endian, offset k: `mem_o` takes `reg_i` shifted right by 8k bits in lanes 0 to 3-k and keeps `mem_i` elsewhere. `byte_en_o` has bit j set exactly for those lanes. Lane j means bits [8j+7:8j], and bit j of `byte_en_o` belongs to lane j.
- R6: Operation code 3 (right store), big-endian, offset k: `mem_o` takes `reg_i` shifted left by 8(3-k) bits in lanes 3-k to 3 and keeps `mem_i` elsewhere. `byte_en_o` marks exactly those lanes.
- R7: For loads, `byte_en_o` is zero and `mem_o` equals `mem_i`. For stores, `reg_o` equals `reg_i`. Address bits above the low two do not affect the data outputs.
- R8: In the whole-word cases (left operations at normalised offset 0, right operations at normalised offset 3), the full word is transferred. For stores in these cases, `byte_en_o` is all ones and `mem_o` equals `reg_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr_i | input | ADDR_W | Effective byte address |
| op_i | input | 2 | 0 left load, 1 right load, 2 left store, 3 right store |
| reg_i | input | DATA_W | Current destination value (loads) or store data (stores) |
| mem_i | input | DATA_W | Aligned memory word read at `aligned_addr_o` |
| aligned_addr_o | output | ADDR_W | Address with the byte-offset bits cleared |
| reg_o | output | DATA_W | Merged register value |
| mem_o | output | DATA_W | Merged memory word for the write-back |
| byte_en_o | output | DATA_W/8 | Per-lane write mask, bit j for bits [8j+7:8j] |

## Verification
Every output is a pure function of the present inputs, so each result is due in the same cycle its stimulus is applied, with no register on the way. The bench changes the inputs just after a rising clock edge and samples all outputs at the following falling edge, after the combinational paths have settled. A big-endian and a little-endian instance share the stimulus. Their outputs are compared with a byte-walking reference model that moves one address at a time. That model never uses the shift-and-mask formulation of the RTL.

// File: rtl/umerge_pkg.sv
package umerge_pkg;

   typedef enum logic [1:0] {
      UM_LD_LEFT  = 2'd0,
      UM_LD_RIGHT = 2'd1,
      UM_ST_LEFT  = 2'd2,
      UM_ST_RIGHT = 2'd3
   } um_op_e;

   function automatic logic um_is_load(input um_op_e op);
      return (op == UM_LD_LEFT) || (op == UM_LD_RIGHT);
   endfunction

   function automatic logic um_is_left(input um_op_e op);
      return (op == UM_LD_LEFT) || (op == UM_ST_LEFT);
   endfunction

endpackage

// File: rtl/umerge_offset.sv
// Splits the byte address into the aligned word address and an offset
// normalised to big-endian numbering (little-endian offsets are mirrored).
module umerge_offset #(
   parameter int ADDR_W     = 32,
   parameter int LANES      = 4,
   parameter bit BIG_ENDIAN = 1'b1,
   localparam int OFF_W     = $clog2(LANES)
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic [ADDR_W-1:0] aligned_o,
   output logic [OFF_W-1:0]  norm_off_o
);

   logic [OFF_W-1:0] raw_off;

   assign raw_off   = addr_i[OFF_W-1:0];
   assign aligned_o = {addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

   generate
      if (BIG_ENDIAN) begin : g_big
         assign norm_off_o = raw_off;
      end else begin : g_little
         assign norm_off_o = OFF_W'(LANES - 1) - raw_off;
      end
   endgenerate

endmodule

// File: rtl/umerge_lane_sel.sv
// Decides per lane whether the byte comes from the shifted fragment.
module umerge_lane_sel #(
   parameter int LANES  = 4,
   localparam int OFF_W = $clog2(LANES)
) (
   input  logic             shift_left_i,
   input  logic [OFF_W-1:0] amt_i,
   output logic [LANES-1:0] take_o
);

   generate
      for (genvar j = 0; j < LANES; j++) begin : g_lane
         localparam logic [OFF_W-1:0] LANE_LO = OFF_W'(j);
         localparam logic [OFF_W-1:0] LANE_HI = OFF_W'(LANES - 1 - j);
         assign take_o[j] = shift_left_i ? (amt_i <= LANE_LO)
                                         : (amt_i <= LANE_HI);
      end
   endgenerate

   always_comb begin
      if (!$isunknown({shift_left_i, amt_i})) begin
         if (amt_i == '0) begin
            p_full_word_r8: assert (take_o == {LANES{1'b1}})
               else $error("zero shift must select every lane");
         end
         p_some_lane_r5: assert ($countones(take_o) >= 1)
            else $error("at least one lane must come from the fragment");
      end
   end

endmodule

// File: rtl/umerge_merge.sv
// Shifts the source by whole bytes and merges it lane by lane with kept data.
module umerge_merge #(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8,
   localparam int OFF_W = $clog2(LANES),
   localparam int SH_W  = OFF_W + 3
) (
   input  logic [DATA_W-1:0] src_i,
   input  logic [DATA_W-1:0] keep_i,
   input  logic              shift_left_i,
   input  logic [OFF_W-1:0]  amt_i,
   input  logic [LANES-1:0]  take_i,
   output logic [DATA_W-1:0] merged_o
);

   logic [SH_W-1:0]   bit_sh;
   logic [DATA_W-1:0] frag;

   assign bit_sh = {amt_i, 3'b000};
   assign frag   = shift_left_i ? (src_i << bit_sh) : (src_i >> bit_sh);

   generate
      for (genvar j = 0; j < LANES; j++) begin : g_lane
         assign merged_o[8*j +: 8] = take_i[j] ? frag[8*j +: 8] : keep_i[8*j +: 8];
      end
   endgenerate

endmodule

// File: rtl/unaligned_merge.sv
module unaligned_merge
   import umerge_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter bit BIG_ENDIAN = 1'b1,
   localparam int LANES     = DATA_W / 8,
   localparam int OFF_W     = $clog2(LANES)
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [1:0]        op_i,
   input  logic [DATA_W-1:0] reg_i,
   input  logic [DATA_W-1:0] mem_i,
   output logic [ADDR_W-1:0] aligned_addr_o,
   output logic [DATA_W-1:0] reg_o,
   output logic [DATA_W-1:0] mem_o,
   output logic [LANES-1:0]  byte_en_o
);

   generate
      if (DATA_W % 8 != 0) begin : g_bad_width
         $error("DATA_W must be a whole number of bytes");
      end
      if (LANES < 2 || (1 << OFF_W) != LANES) begin : g_bad_lanes
         $error("DATA_W/8 must be a power of two of at least 2");
      end
      if (ADDR_W <= OFF_W) begin : g_bad_addr
         $error("ADDR_W too narrow for the byte offset");
      end
   endgenerate

   um_op_e           op;
   logic             is_load;
   logic             is_left;
   logic             shift_left;
   logic [OFF_W-1:0] norm_off;
   logic [OFF_W-1:0] amt;
   logic [LANES-1:0] take;
   logic [DATA_W-1:0] src;
   logic [DATA_W-1:0] keep;
   logic [DATA_W-1:0] merged;

   assign op         = um_op_e'(op_i);
   assign is_load    = um_is_load(op);
   assign is_left    = um_is_left(op);
   // left load and right store move bytes toward the high lanes
   assign shift_left = (op == UM_LD_LEFT) || (op == UM_ST_RIGHT);
   assign amt        = is_left ? norm_off : OFF_W'(LANES - 1) - norm_off;
   assign src        = is_load ? mem_i : reg_i;
   assign keep       = is_load ? reg_i : mem_i;

   umerge_offset #(
      .ADDR_W    (ADDR_W),
      .LANES     (LANES),
      .BIG_ENDIAN(BIG_ENDIAN)
   ) u_offset (
      .addr_i    (addr_i),
      .aligned_o (aligned_addr_o),
      .norm_off_o(norm_off)
   );

   umerge_lane_sel #(
      .LANES(LANES)
   ) u_lane_sel (
      .shift_left_i(shift_left),
      .amt_i       (amt),
      .take_o      (take)
   );

   umerge_merge #(
      .DATA_W(DATA_W)
   ) u_merge (
      .src_i       (src),
      .keep_i      (keep),
      .shift_left_i(shift_left),
      .amt_i       (amt),
      .take_i      (take),
      .merged_o    (merged)
   );

   assign reg_o     = is_load ? merged : reg_i;
   assign mem_o     = is_load ? mem_i  : merged;
   assign byte_en_o = is_load ? '0     : take;

   logic untouched_ok;

   always_comb begin
      untouched_ok = 1'b1;
      for (int j = 0; j < LANES; j++) begin
         if (!byte_en_o[j] && (mem_o[8*j +: 8] != mem_i[8*j +: 8])) untouched_ok = 1'b0;
      end
      if (!$isunknown({addr_i, op_i, reg_i, mem_i})) begin
         p_aligned_r1: assert (aligned_addr_o[OFF_W-1:0] == '0 &&
                               aligned_addr_o[ADDR_W-1:OFF_W] == addr_i[ADDR_W-1:OFF_W])
            else $error("aligned address mismatch");
         if (is_load) begin
            p_load_no_write_r7: assert (byte_en_o == '0 && mem_o == mem_i)
               else $error("load must not write memory");
         end else begin
            p_store_reg_pass_r7: assert (reg_o == reg_i)
               else $error("store must not alter the register value");
            p_store_keeps_r6: assert (untouched_ok)
               else $error("store changed a disabled lane");
            if (byte_en_o == {LANES{1'b1}}) begin
               p_store_whole_r8: assert (mem_o == reg_i)
                  else $error("whole-word store must copy the register");
            end
         end
      end
   end

endmodule

// File: tb/test_unaligned_merge.sv
module test_unaligned_merge;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;
   localparam int NVEC       = 8;

   // {op, addr, reg, mem}
   localparam logic [97:0] VEC [NVEC] = '{
      {2'd0, 32'h0000_1001, 32'hAABB_CCDD, 32'h1122_3344},
      {2'd1, 32'h0000_2002, 32'hAABB_CCDD, 32'h1122_3344},
      {2'd2, 32'hFFFF_FFFF, 32'h0102_0304, 32'hF0E1_D2C3},
      {2'd3, 32'h8000_0000, 32'h0102_0304, 32'hF0E1_D2C3},
      {2'd0, 32'h1234_5673, 32'h00FF_807F, 32'h5A5A_A5A5},
      {2'd1, 32'h1234_5670, 32'h00FF_807F, 32'h5A5A_A5A5},
      {2'd2, 32'hDEAD_BEE2, 32'hCAFE_BABE, 32'h0000_0000},
      {2'd3, 32'hDEAD_BEE1, 32'hFFFF_FFFF, 32'h1357_9BDF}
   };

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [31:0] addr, rv, mv;
   logic [1:0]  op;
   logic [31:0] be_addr, be_reg, be_mem, le_addr, le_reg, le_mem;
   logic [3:0]  be_en, le_en;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   unaligned_merge #(.BIG_ENDIAN(1'b1)) i_unaligned_merge (
      .addr_i(addr), .op_i(op), .reg_i(rv), .mem_i(mv),
      .aligned_addr_o(be_addr), .reg_o(be_reg), .mem_o(be_mem), .byte_en_o(be_en)
   );

   unaligned_merge #(.BIG_ENDIAN(1'b0)) i_unaligned_merge_le (
      .addr_i(addr), .op_i(op), .reg_i(rv), .mem_i(mv),
      .aligned_addr_o(le_addr), .reg_o(le_reg), .mem_o(le_mem), .byte_en_o(le_en)
   );

   // Byte-walking reference: starts at the addressed byte and moves one
   // address at a time until the word boundary is reached.
   function automatic void ref_model(input bit big, input logic [1:0] o,
                                     input logic [1:0] off, input logic [31:0] r,
                                     input logic [31:0] m, output logic [31:0] er,
                                     output logic [31:0] em, output logic [3:0] eb);
      bit left;
      bit load;
      int a, p, step, ln;
      er   = r;
      em   = m;
      eb   = 4'b0000;
      left = (o == 2'd0) || (o == 2'd2);
      load = (o < 2'd2);
      a    = int'(off);
      p    = left ? 3 : 0;
      step = (left == big) ? 1 : -1;
      for (int i = 0; i < 4; i++) begin
         if (a >= 0 && a <= 3) begin
            ln = big ? 3 - a : a;
            if (load) er[8*p +: 8] = m[8*ln +: 8];
            else begin
               em[8*ln +: 8] = r[8*p +: 8];
               eb[ln] = 1'b1;
            end
            a = a + step;
            p = left ? p - 1 : p + 1;
         end
      end
   endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic apply(input logic [1:0] o, input logic [31:0] a,
                        input logic [31:0] r, input logic [31:0] m);
      @(posedge clk);
      op = o; addr = a; rv = r; mv = m;
      @(negedge clk);
   endtask

   function automatic string req_of(input bit big, input logic [1:0] o);
      if (!big) return "R4";
      case (o)
         2'd0: return "R2";
         2'd1: return "R3";
         2'd2: return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic check_both();
      logic [31:0] er, em;
      logic [3:0]  eb;
      string tag;
      ref_model(1'b1, op, addr[1:0], rv, mv, er, em, eb);
      tag = req_of(1'b1, op);
      check(tag, "BE reg", be_reg, er);
      check(tag, "BE mem", be_mem, em);
      check((op < 2) ? "R7" : tag, "BE byte_en", {28'd0, be_en}, {28'd0, eb});
      check("R1", "BE aligned", be_addr, {addr[31:2], 2'b00});
      ref_model(1'b0, op, addr[1:0], rv, mv, er, em, eb);
      check("R4", "LE reg", le_reg, er);
      check("R4", "LE mem", le_mem, em);
      check("R4", "LE byte_en", {28'd0, le_en}, {28'd0, eb});
      check("R1", "LE aligned", le_addr, {addr[31:2], 2'b00});
   endtask

   initial begin
      op = 2'd0; addr = '0; rv = '0; mv = '0;
      @(negedge clk);
      // quiescent inputs: everything zero
      check("R7", "idle reg", be_reg, 32'h0);
      check("R7", "idle byte_en", {28'd0, be_en}, 32'h0);

      // table of vectors, both byte orders against the reference model
      for (int v = 0; v < NVEC; v++) begin
         apply(VEC[v][97:96], VEC[v][95:64], VEC[v][63:32], VEC[v][31:0]);
         check_both();
      end

      // every operation at every offset, two data patterns
      for (int o = 0; o < 4; o++) begin
         for (int k = 0; k < 4; k++) begin
            apply(2'(o), 32'h4000_0010 | 32'(k), 32'hAABB_CCDD, 32'h1122_3344);
            check_both();
            apply(2'(o), 32'h7FFF_FFF4 | 32'(k), 32'h00FF_807F, 32'hF0E1_D2C3);
            check_both();
         end
      end

      // directed corner values computed by hand
      apply(2'd0, 32'h0000_0001, 32'hAABB_CCDD, 32'h1122_3344);
      check("R2", "BE left load off1", be_reg, 32'h2233_44DD);
      check("R4", "LE left load off1", le_reg, 32'h3344_CCDD);
      apply(2'd3, 32'h0000_0001, 32'hAABB_CCDD, 32'h1122_3344);
      check("R6", "BE right store off1 mem", be_mem, 32'hCCDD_3344);
      check("R6", "BE right store off1 en", {28'd0, be_en}, 32'hC);
      check("R7", "store reg passthrough", be_reg, 32'hAABB_CCDD);
      apply(2'd2, 32'h0000_0002, 32'hAABB_CCDD, 32'h1122_3344);
      check("R5", "BE left store off2 mem", be_mem, 32'h1122_AABB);
      check("R5", "BE left store off2 en", {28'd0, be_en}, 32'h3);
      // whole-word cases
      apply(2'd0, 32'h0000_0000, 32'hAABB_CCDD, 32'h1122_3344);
      check("R8", "BE left load off0 whole", be_reg, 32'h1122_3344);
      apply(2'd1, 32'h0000_0000, 32'hAABB_CCDD, 32'h1122_3344);
      check("R8", "LE right load off0 whole", le_reg, 32'h1122_3344);
      apply(2'd2, 32'h0000_0003, 32'hAABB_CCDD, 32'h1122_3344);
      check("R8", "LE left store off3 whole", le_mem, 32'hAABB_CCDD);
      check("R8", "LE left store off3 en", {28'd0, le_en}, 32'hF);
      apply(2'd3, 32'h0000_0003, 32'hAABB_CCDD, 32'h1122_3344);
      check("R8", "BE right store off3 en", {28'd0, be_en}, 32'hF);
      // upper address bits change nothing but the aligned address
      apply(2'd1, 32'hFFFF_FFF2, 32'hAABB_CCDD, 32'h1122_3344);
      check("R7", "high addr bits ignored", be_reg, 32'hAA11_2233);
      check("R1", "aligned high addr", be_addr, 32'hFFFF_FFF0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule